// File: doc/BRIEF.md
# UART Character Framer and Baud Divider

This block is the serial engine of a 16550-style asynchronous port. A 16-bit divisor cuts the system clock down to a sampling tick that runs at sixteen times the bit rate. The transmitter and the receiver both use this one tick. The transmitter takes a byte over a valid/ready handshake and sends it as a framed character. The receiver rebuilds characters from the serial input and returns each one as a single-cycle pulse with its error flags. Surrounding FIFOs and register decode sit outside this block and connect to these parallel ports.

The character format is set by static inputs:

- Word length of 5 to 8 bits.
- Parity of none, even, odd, or a constant (stick) bit.
- One stop bit or two stop bits.

A break-send input forces the serial line low. A loopback input sends the transmitter's output straight into the receiver and holds the external output pin at the idle level.

Transmit states:

- `TX_IDLE`: line high, ready. Goes to `TX_START` when a byte is accepted.
- `TX_START`: goes to `TX_DATA` after 16 ticks.
- `TX_DATA`: goes to `TX_PAR` (parity enabled) or `TX_STOP` (parity off) after the last data bit.
- `TX_PAR`: goes to `TX_STOP` after 16 ticks.
- `TX_STOP`: goes back to `TX_IDLE` after the stop time.

Receive states:

- `RX_IDLE`: goes to `RX_START` on a low sample.
- `RX_START`: at the 8th sample, returns to `RX_IDLE` if the line is high (false start), or goes to `RX_DATA` if it is low.
- `RX_DATA`: goes to `RX_PAR` or `RX_STOP` after the last data bit.
- `RX_PAR`: goes to `RX_STOP`.
- `RX_STOP`: goes to `RX_BRK` if the whole character was low, otherwise to `RX_IDLE`.
- `RX_BRK`: goes to `RX_IDLE` when the line returns high.

Top module: `uart_serial_core`

## Requirements
- R1: A tick is produced once every `baud_div` clocks (a value of 0 acts as 1), and every bit lasts 16 ticks. An 8N1 frame therefore takes 160 × `baud_div` clocks from acceptance until `tx_ready` returns.
- R2: The `word_len` code selects the data width: 0 = 5 bits, 1 = 6 bits, 2 = 7 bits, 3 = 8 bits. Data bits are sent least significant bit first, starting from bit 0 of `tx_data`.
- R3: When `par_en`=1, one parity bit follows the data. With `par_stick`=0, it makes the count of ones odd if `par_odd`=1 and even if `par_odd`=0. With `par_stick`=1, it is the constant value of `par_odd`.
- R4: `tx_ready` is low from the acceptance cycle until the stop time ends. The stop time is 16 ticks with `stop_two`=0. With `stop_two`=1 it is 32 ticks, or 24 ticks when the width is 5 bits.
- R5: The idle line is high, and each character begins with one low start bit of 16 ticks.
- R6: A low level must still be low at the 8th sample to count as a start bit; a shorter low pulse yields no character. Each later bit is sampled at its centre. `rx_valid` pulses for one cycle at the first stop-bit sample and carries the right-aligned data in `rx_data`.
- R7: `rx_par_err` is set when the received parity bit differs from the bit R3 would generate for the received data.
- R8: `rx_frm_err` is set when the first stop bit samples low.
- R9: A character that is low in every bit through the first stop sample is reported once, with `rx_brk`=1, `rx_frm_err`=1 and `rx_data`=0. No further character is reported until the line has returned high.
- R10: While `brk_send`=1, the transmit line is low. The transmit sequencing and the timing of `tx_ready` are unchanged.
- R11: With `loop_en`=1, the receiver takes the transmit line, `sout` stays high, and `sin` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | DIV_W | Clock divisor for the 16x tick |
| word_len | input | 2 | Data width code (0..3 means 5..8 bits) |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | Odd parity select, or the stick value |
| par_stick | input | 1 | Constant parity bit select |
| stop_two | input | 1 | Two (or 1.5) stop bits |
| brk_send | input | 1 | Force the transmit line low |
| loop_en | input | 1 | Internal loopback |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Transmitter idle; accepts a byte |
| rx_data | output | 8 | Received character, right-aligned |
| rx_valid | output | 1 | One-cycle pulse per received character |
| rx_par_err | output | 1 | Parity mismatch on the reported character |
| rx_frm_err | output | 1 | First stop bit sampled low |
| rx_brk | output | 1 | Reported character was a break |
| sin | input | 1 | Serial input |
| sout | output | 1 | Serial output |

## Verification
In loopback, break forcing and an ordinary character transmission can be active in the same cycles. The bench raises `brk_send` in the same cycle that it offers 0xFF with `loop_en` set. It then checks three things: `tx_ready` still returns within the normal 8N1 frame time, `sout` never leaves high, and the receiver reports exactly one character, marked as a break with zero data. A second check sends a false start and then a normal frame, to confirm that the receiver returns to the idle state and recovers.

// File: rtl/uart_core_pkg.sv
package uart_core_pkg;

    localparam int OVERSAMPLE = 16;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PAR,
        TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_BRK
    } rx_state_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        logic       par_odd;
        logic       par_stick;
        logic       two_stop;
    } frame_cfg_t;

    // Mask keeping the active data bits of a word.
    function automatic logic [7:0] word_mask(input logic [1:0] wlen);
        return 8'hFF >> (3'd3 - {1'b0, wlen});
    endfunction

    // Parity bit value for a word under a given format.
    function automatic logic gen_parity(input logic [7:0] d, input frame_cfg_t c);
        if (c.par_stick) begin
            return c.par_odd;
        end
        return (^(d & word_mask(c.wlen))) ^ c.par_odd;
    endfunction

    // Stop time in ticks: 16, 32, or 24 for a 5-bit word with two stops.
    function automatic logic [5:0] stop_ticks(input frame_cfg_t c);
        if (!c.two_stop) begin
            return 6'd16;
        end
        if (c.wlen == 2'd0) begin
            return 6'd24;
        end
        return 6'd32;
    endfunction

endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last_cnt;

    assign last_cnt = (divisor == '0) ? '0 : divisor - DIV_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= last_cnt) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + DIV_W'(1);
            tick <= 1'b0;
        end
    end

    // R1: with a divisor above one, ticks never fall in adjacent cycles
    a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && divisor > DIV_W'(1)) |=> (!tick || divisor != $past(divisor)));

endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import uart_core_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  frame_cfg_t cfg,
    input  logic       brk_force,
    input  logic [7:0] din,
    input  logic       din_valid,
    output logic       din_ready,
    output logic       line
);

    tx_state_e  state;
    tx_state_e  nxt;
    frame_cfg_t cfg_q;
    logic [7:0] shreg;
    logic       par_q;
    logic [4:0] tcnt;
    logic [2:0] bidx;
    logic [2:0] last_idx;
    logic [5:0] blen;
    logic       bit_done;
    logic       line_raw;

    assign last_idx = 3'd4 + {1'b0, cfg_q.wlen};
    assign blen     = (state == TX_STOP) ? stop_ticks(cfg_q) : 6'(OVERSAMPLE);
    assign bit_done = tick && ({1'b0, tcnt} == blen - 6'd1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TX_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:  if (din_valid) nxt = TX_START;
            TX_START: if (bit_done) nxt = TX_DATA;
            TX_DATA:  if (bit_done && bidx == last_idx) nxt = cfg_q.par_en ? TX_PAR : TX_STOP;
            TX_PAR:   if (bit_done) nxt = TX_STOP;
            TX_STOP:  if (bit_done) nxt = TX_IDLE;
            default:  nxt = TX_IDLE;
        endcase
    end

    // Character and bit timing datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            shreg <= '0;
            par_q <= 1'b0;
            tcnt  <= '0;
            bidx  <= '0;
        end else if (state == TX_IDLE) begin
            tcnt <= '0;
            bidx <= '0;
            if (din_valid) begin
                cfg_q <= cfg;
                shreg <= din;
                par_q <= gen_parity(din, cfg);
            end
        end else if (tick) begin
            if (bit_done) begin
                tcnt <= '0;
                if (state == TX_DATA) begin
                    shreg <= {1'b0, shreg[7:1]};
                    bidx  <= bidx + 3'd1;
                end
            end else begin
                tcnt <= tcnt + 5'd1;
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            TX_IDLE:  line_raw = 1'b1;
            TX_START: line_raw = 1'b0;
            TX_DATA:  line_raw = shreg[0];
            TX_PAR:   line_raw = par_q;
            TX_STOP:  line_raw = 1'b1;
            default:  line_raw = 1'b1;
        endcase
        din_ready = (state == TX_IDLE);
        line      = brk_force ? 1'b0 : line_raw;
    end

    // R4: an accepted byte makes the transmitter busy in the next cycle
    a_r4_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (din_valid && din_ready) |=> !din_ready);

    // R5: an idle, unforced transmitter holds the line high
    a_r5_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        (din_ready && !brk_force) |-> line);

    // R2: the data bit index never passes the selected width
    a_r2_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_DATA) |-> (bidx <= last_idx));

    // R4: stop time is high unless a break is being forced
    a_r4_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_STOP && !brk_force) |-> line);

endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_core_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  frame_cfg_t cfg,
    input  logic       rxd,
    output logic       valid_o,
    output logic [7:0] data_o,
    output logic       perr_o,
    output logic       ferr_o,
    output logic       brk_o
);

    rx_state_e  state;
    rx_state_e  nxt;
    logic [3:0] tcnt;
    logic [2:0] bidx;
    logic [2:0] last_idx;
    logic [7:0] shreg;
    logic [7:0] data_al;
    logic       all_low;
    logic       perr_q;
    logic       start_chk;
    logic       samp;

    assign last_idx  = 3'd4 + {1'b0, cfg.wlen};
    assign data_al   = shreg >> (3'd3 - {1'b0, cfg.wlen});
    assign start_chk = tick && (tcnt == 4'd7);
    assign samp      = tick && (tcnt == 4'd15);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (tick && !rxd) nxt = RX_START;
            RX_START: if (start_chk) nxt = rxd ? RX_IDLE : RX_DATA;
            RX_DATA:  if (samp && bidx == last_idx) nxt = cfg.par_en ? RX_PAR : RX_STOP;
            RX_PAR:   if (samp) nxt = RX_STOP;
            RX_STOP:  if (samp) nxt = (!rxd && all_low) ? RX_BRK : RX_IDLE;
            RX_BRK:   if (tick && rxd) nxt = RX_IDLE;
            default:  nxt = RX_IDLE;
        endcase
    end

    // Sampling datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt    <= '0;
            bidx    <= '0;
            shreg   <= '0;
            all_low <= 1'b1;
            perr_q  <= 1'b0;
            valid_o <= 1'b0;
            data_o  <= '0;
            perr_o  <= 1'b0;
            ferr_o  <= 1'b0;
            brk_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (state == RX_IDLE || state == RX_BRK) begin
                tcnt    <= '0;
                bidx    <= '0;
                all_low <= 1'b1;
                perr_q  <= 1'b0;
            end else if (tick) begin
                if (state == RX_START && tcnt == 4'd7) begin
                    tcnt <= '0;
                end else begin
                    tcnt <= tcnt + 4'd1;
                end
                if (samp) begin
                    unique case (state)
                        RX_DATA: begin
                            shreg <= {rxd, shreg[7:1]};
                            bidx  <= bidx + 3'd1;
                            if (rxd) all_low <= 1'b0;
                        end
                        RX_PAR: begin
                            perr_q <= (rxd != gen_parity(data_al, cfg));
                            if (rxd) all_low <= 1'b0;
                        end
                        RX_STOP: begin
                            valid_o <= 1'b1;
                            data_o  <= data_al;
                            perr_o  <= perr_q;
                            ferr_o  <= !rxd;
                            brk_o   <= !rxd && all_low;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // R6: each character is reported by a single-cycle pulse
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R9: a break carries zero data and a framing error
    a_r9_break_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && brk_o) |-> (data_o == 8'h00 && ferr_o));

    // R8: a character with a good stop bit is never a break
    a_r8_good_stop_no_break: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ferr_o) |-> !brk_o);

    // R6: the data index stays within the selected width
    a_r6_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_DATA) |-> (bidx <= last_idx));

endmodule

// File: rtl/uart_serial_core.sv
module uart_serial_core
    import uart_core_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] baud_div,
    input  logic [1:0]       word_len,
    input  logic             par_en,
    input  logic             par_odd,
    input  logic             par_stick,
    input  logic             stop_two,
    input  logic             brk_send,
    input  logic             loop_en,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             rx_par_err,
    output logic             rx_frm_err,
    output logic             rx_brk,
    input  logic             sin,
    output logic             sout
);

    frame_cfg_t cfg;
    logic       tick;
    logic       tx_line;
    logic       sin_m;
    logic       sin_s;
    logic       rx_line;

    assign cfg.wlen      = word_len;
    assign cfg.par_en    = par_en;
    assign cfg.par_odd   = par_odd;
    assign cfg.par_stick = par_stick;
    assign cfg.two_stop  = stop_two;

    // Two-stage synchronizer on the serial input
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sin_m <= 1'b1;
            sin_s <= 1'b1;
        end else begin
            sin_m <= sin;
            sin_s <= sin_m;
        end
    end

    assign rx_line = loop_en ? tx_line : sin_s;
    assign sout    = loop_en ? 1'b1 : tx_line;

    uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (baud_div),
        .tick    (tick)
    );

    uart_tx_fsm u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cfg       (cfg),
        .brk_force (brk_send),
        .din       (tx_data),
        .din_valid (tx_valid),
        .din_ready (tx_ready),
        .line      (tx_line)
    );

    uart_rx_fsm u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cfg     (cfg),
        .rxd     (rx_line),
        .valid_o (rx_valid),
        .data_o  (rx_data),
        .perr_o  (rx_par_err),
        .ferr_o  (rx_frm_err),
        .brk_o   (rx_brk)
    );

endmodule

// File: tb/test_uart_serial_core.sv
module test_uart_serial_core;

    localparam int DIV_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] baud_div = 16'd2;
    logic [1:0]       word_len = 2'd3;
    logic             par_en = 1'b0;
    logic             par_odd = 1'b0;
    logic             par_stick = 1'b0;
    logic             stop_two = 1'b0;
    logic             brk_send = 1'b0;
    logic             loop_en = 1'b0;
    logic [7:0]       tx_data = 8'h00;
    logic             tx_valid = 1'b0;
    logic             tx_ready;
    logic [7:0]       rx_data;
    logic             rx_valid;
    logic             rx_par_err;
    logic             rx_frm_err;
    logic             rx_brk;
    logic             sin = 1'b1;
    logic             sout;

    always #10 clk = ~clk;

    uart_serial_core #(.DIV_W(DIV_W)) i_uart_serial_core (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .word_len(word_len),
        .par_en(par_en), .par_odd(par_odd), .par_stick(par_stick), .stop_two(stop_two),
        .brk_send(brk_send), .loop_en(loop_en), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_brk(rx_brk),
        .sin(sin), .sout(sout)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int div_now = 2;
    int fw = 8;
    bit fpen = 0, fpodd = 0, fstick = 0, ftwo = 0;

    int   rx_cnt = 0;
    int   cap_d = 0;
    int   cap_pe = 0, cap_fe = 0, cap_bk = 0;

    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            rx_cnt = rx_cnt + 1;
            cap_d  = int'(rx_data);
            cap_pe = int'(rx_par_err);
            cap_fe = int'(rx_frm_err);
            cap_bk = int'(rx_brk);
        end
    end

    task automatic check(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic check_range(input string req, input string what, input int got,
                               input int lo, input int hi);
        checks++;
        if (got < lo || got > hi) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d..%0d", req, what, got, lo, hi);
        end
    endtask

    task automatic set_fmt(input int w, input bit pe, input bit po, input bit ps, input bit two);
        fw = w; fpen = pe; fpodd = po; fstick = ps; ftwo = two;
        @(negedge clk);
        word_len  = 2'(w - 5);
        par_en    = pe;
        par_odd   = po;
        par_stick = ps;
        stop_two  = two;
    endtask

    task automatic set_div(input int d);
        div_now = d;
        @(negedge clk);
        baud_div = 16'(d);
        repeat (4) @(negedge clk);
    endtask

    function automatic int exp_par(input int d);
        int ones = 0;
        if (fstick) return int'(fpodd);
        for (int i = 0; i < fw; i++) ones += (d >> i) & 1;
        return (ones & 1) ^ int'(fpodd);
    endfunction

    function automatic int frame_ticks();
        int st = ftwo ? ((fw == 5) ? 24 : 32) : 16;
        return 16 * (1 + fw + int'(fpen)) + st;
    endfunction

    // Transmit one byte and decode it from sout
    task automatic tx_send_check(input string req, input int d);
        int bitc = 16 * div_now;
        int got = 0;
        int elapsed = 0;
        int t = frame_ticks() * div_now;
        @(negedge clk);
        tx_data  = 8'(d);
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        check("R4", {req, " busy after accept"}, int'(tx_ready), 0);
        repeat (bitc / 2) @(negedge clk);
        elapsed += bitc / 2;
        check("R5", {req, " start bit"}, int'(sout), 0);
        for (int i = 0; i < fw; i++) begin
            repeat (bitc) @(negedge clk);
            elapsed += bitc;
            got |= int'(sout) << i;
        end
        check("R2", {req, " data bits"}, got, d & ((1 << fw) - 1));
        if (fpen) begin
            repeat (bitc) @(negedge clk);
            elapsed += bitc;
            check("R3", {req, " parity bit"}, int'(sout), exp_par(d));
        end
        repeat (bitc) @(negedge clk);
        elapsed += bitc;
        check("R5", {req, " stop level"}, int'(sout), 1);
        while (!tx_ready && elapsed < t + 100) begin
            @(negedge clk);
            elapsed++;
        end
        check_range("R4", {req, " frame clocks"}, elapsed, t - div_now, t + 1);
    endtask

    // Drive one character onto sin
    task automatic rx_drive(input int d, input int pbit, input bit stop_ok);
        int bitc = 16 * div_now;
        @(negedge clk);
        sin = 1'b0;
        repeat (bitc) @(negedge clk);
        for (int i = 0; i < fw; i++) begin
            sin = ((d >> i) & 1) != 0;
            repeat (bitc) @(negedge clk);
        end
        if (fpen) begin
            sin = pbit != 0;
            repeat (bitc) @(negedge clk);
        end
        if (stop_ok) begin
            sin = 1'b1;
            repeat (ftwo ? 2 * bitc : bitc) @(negedge clk);
        end else begin
            sin = 1'b0;
            repeat (bitc / 2 + 2 * div_now + 3) @(negedge clk);
            sin = 1'b1;
        end
        repeat (2 * bitc) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R5", "reset sout", int'(sout), 1);
        check("R4", "reset tx_ready", int'(tx_ready), 1);
        check("R6", "reset rx_valid", int'(rx_valid), 0);
    endtask

    task automatic t_tx_formats();
        set_fmt(8, 0, 0, 0, 0);
        tx_send_check("R1 8N1", 8'hA5);
        set_fmt(7, 1, 0, 0, 0);
        tx_send_check("R3 7E1", 8'h35);
        set_fmt(6, 1, 1, 0, 0);
        tx_send_check("R3 6O1", 8'h2A);
        set_fmt(8, 1, 1, 1, 0);
        tx_send_check("R3 stick one", 8'h00);
        set_fmt(8, 1, 0, 1, 0);
        tx_send_check("R3 stick zero", 8'hFF);
        set_fmt(5, 0, 0, 0, 1);
        tx_send_check("R4 5 bits 1.5 stop", 8'h15);
        set_fmt(8, 0, 0, 0, 1);
        tx_send_check("R4 8 bits 2 stop", 8'hC3);
    endtask

    task automatic t_divisor();
        set_fmt(8, 0, 0, 0, 0);
        set_div(3);
        tx_send_check("R1 div3", 8'h3C);
        set_div(1);
        tx_send_check("R1 div1", 8'h81);
        set_div(2);
    endtask

    task automatic t_rx_basic();
        int c0;
        set_fmt(8, 0, 0, 0, 0);
        c0 = rx_cnt;
        rx_drive(8'h3C, 0, 1);
        check("R6", "8N1 count", rx_cnt - c0, 1);
        check("R6", "8N1 data", cap_d, 8'h3C);
        check("R8", "8N1 no frame err", cap_fe, 0);
        check("R9", "8N1 no break", cap_bk, 0);
        set_fmt(5, 0, 0, 0, 1);
        c0 = rx_cnt;
        rx_drive(8'h1B, 0, 1);
        check("R6", "5-bit count", rx_cnt - c0, 1);
        check("R2", "5-bit data", cap_d, 8'h1B);
    endtask

    task automatic t_rx_parity();
        set_fmt(7, 1, 1, 0, 0);
        rx_drive(8'h55, exp_par(8'h55), 1);
        check("R7", "good odd parity", cap_pe, 0);
        check("R7", "good odd data", cap_d, 8'h55);
        rx_drive(8'h55, 1 - exp_par(8'h55), 1);
        check("R7", "bad odd parity", cap_pe, 1);
        set_fmt(8, 1, 0, 1, 0);
        rx_drive(8'h0F, 1, 1);
        check("R7", "stick zero got one", cap_pe, 1);
    endtask

    task automatic t_rx_frame();
        int c0;
        set_fmt(8, 0, 0, 0, 0);
        c0 = rx_cnt;
        rx_drive(8'h81, 0, 0);
        check("R8", "frame err count", rx_cnt - c0, 1);
        check("R8", "frame err flag", cap_fe, 1);
        check("R8", "frame err not break", cap_bk, 0);
        check("R8", "frame err data", cap_d, 8'h81);
    endtask

    task automatic t_rx_glitch();
        int c0 = rx_cnt;
        @(negedge clk);
        sin = 1'b0;
        repeat (3 * div_now) @(negedge clk);
        sin = 1'b1;
        repeat (40 * div_now) @(negedge clk);
        check("R6", "false start ignored", rx_cnt - c0, 0);
    endtask

    task automatic t_rx_break();
        int c0 = rx_cnt;
        int bitc = 16 * div_now;
        set_fmt(8, 0, 0, 0, 0);
        @(negedge clk);
        sin = 1'b0;
        repeat (12 * bitc) @(negedge clk);
        sin = 1'b1;
        repeat (2 * bitc) @(negedge clk);
        check("R9", "break single report", rx_cnt - c0, 1);
        check("R9", "break flag", cap_bk, 1);
        check("R9", "break data", cap_d, 0);
        check("R9", "break frame flag", cap_fe, 1);
        rx_drive(8'h6E, 0, 1);
        check("R9", "recovery count", rx_cnt - c0, 2);
        check("R9", "recovery data", cap_d, 8'h6E);
    endtask

    task automatic t_brk_send();
        @(negedge clk);
        brk_send = 1'b1;
        repeat (3) @(negedge clk);
        check("R10", "break drives low", int'(sout), 0);
        brk_send = 1'b0;
        @(negedge clk);
        check("R10", "release to idle", int'(sout), 1);
    endtask

    task automatic t_loopback();
        int c0;
        int lows = 0;
        int n = 0;
        set_fmt(8, 0, 0, 0, 0);
        @(negedge clk);
        loop_en = 1'b1;
        sin = 1'b0;
        repeat (8) @(negedge clk);
        c0 = rx_cnt;
        tx_data = 8'h5A;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        while (!tx_ready && n < 2000) begin
            if (!sout) lows++;
            @(negedge clk);
            n++;
        end
        repeat (16 * div_now) @(negedge clk);
        check("R11", "sout held high", lows, 0);
        check("R11", "looped count", rx_cnt - c0, 1);
        check("R11", "looped data", cap_d, 8'h5A);
        sin = 1'b1;
        repeat (5) @(negedge clk);
        loop_en = 1'b0;
    endtask

    // Break forcing overlaps a transmission while looped back
    task automatic t_loop_break_overlap();
        int c0;
        int lows = 0;
        int n = 1;
        int bitc = 16 * div_now;
        int t;
        set_fmt(8, 0, 0, 0, 0);
        t = frame_ticks() * div_now;
        @(negedge clk);
        loop_en = 1'b1;
        repeat (4) @(negedge clk);
        c0 = rx_cnt;
        tx_data  = 8'hFF;
        tx_valid = 1'b1;
        brk_send = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        while (!tx_ready && n < t + 100) begin
            if (!sout) lows++;
            @(negedge clk);
            n++;
        end
        check_range("R10", "tx timing under break", n, t - div_now, t + 1);
        repeat (14 * bitc - n) @(negedge clk);
        brk_send = 1'b0;
        repeat (2 * bitc) @(negedge clk);
        check("R11", "sout high under break", lows, 0);
        check("R9", "overlap single report", rx_cnt - c0, 1);
        check("R9", "overlap break flag", cap_bk, 1);
        check("R9", "overlap zero data", cap_d, 0);
        loop_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_tx_formats();
        t_divisor();
        t_rx_basic();
        t_rx_parity();
        t_rx_frame();
        t_rx_glitch();
        t_rx_break();
        t_brk_send();
        t_loopback();
        t_loop_break_overlap();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule